// File: doc/BRIEF.md
# Software-Refilled Address Translation Cache

This block is a small, fully associative translation cache for a 32-bit byte-addressed processor. It maps 20-bit virtual page numbers onto 26-bit frame numbers, which gives 38-bit physical addresses with 4096-byte pages. Every access is looked up in the same cycle. The block checks the access kind (read, write or fetch) against the entry's permission bits. It then either returns the translated address or raises a fault.

Software owns the contents. A refill takes two register writes. The first write puts the page number and the permissions into the page/perm register. The second write puts the frame number into the frame register, and that second write commits the entry. A new page takes the lowest free slot. When every slot is occupied, the least recently used slot is replaced. When a fault occurs, the block overwrites the page/perm register with the faulting page and a code that names the violated permission, so the handler can read what went wrong.

Bit 31 of each virtual address selects translation for that single access. With bit 31 clear, the address passes through untranslated and no fault is possible.

Top module: `soft_tlb`

## Requirements
- R1: When reqValid is high and reqAddr[31] is 0, physAddr equals reqAddr zero-extended to 38 bits, hit and fault are both 0, and the page/perm register is not changed by the lookup.
- R2: When reqValid is high and reqAddr[31] is 1 and the access is permitted, hit is 1 in the same cycle and physAddr is {entry frame, reqAddr[11:0]}. The entry is selected by reqAddr[31:12].
- R3: Permission bits are v=bit3, r=bit2, w=bit1, x=bit0, and bit4 (m) has no effect. reqKind 00 and 11 mean read and need r, 01 means write and needs w, and 10 means fetch and needs x. An access is permitted only if v and the needed bit are both set. Otherwise fault is 1.
- R4: On a clock edge where fault is 1, the page/perm register becomes {reqAddr[31:12], 7'b0, code}. The code is 5'b01000 for a miss or for an entry with v clear. For a permission violation it is 5'b00100 (read), 5'b00010 (write) or 5'b00001 (fetch).
- R5: If a fault and a software write to the page/perm register happen in the same cycle, the fault record is stored and the software write is lost.
- R6: regWrSel 0 selects the page/perm register and regWrSel 1 selects the frame register. A write stores all 32 bits. regRdData combinationally returns the register picked by regRdSel (0 page/perm, 1 frame).
- R7: A write to the frame register commits an entry with page = page/perm[31:12], permissions = page/perm[3:0] and frame = regWrData[31:6]. The page/perm value used is the one held before that edge. The entry is usable from the next cycle.
- R8: Installing a page that already has an entry overwrites that entry in place, and no other entry is disturbed.
- R9: The block has eight slots. An install of a new page takes the lowest-index free slot. When all slots are full, it takes the least recently used slot, where only a successful translation (hit) or an install counts as a use. On a cycle with both an install and a hit, only the install counts as a use.
- R10: Reset empties every slot, clears both registers to zero and orders the LRU ranking with slot 0 as most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request present |
| reqAddr | input | 32 | Virtual address; bit 31 enables translation |
| reqKind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| hit | output | 1 | Translation succeeded |
| fault | output | 1 | Translation refused (miss or permission) |
| physAddr | output | 38 | Physical address |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 1 | 0 page/perm register, 1 frame register |
| regWrData | input | 32 | Register write data |
| regRdSel | input | 1 | 0 page/perm register, 1 frame register |
| regRdData | output | 32 | Selected register contents |

## Verification
The hardest situation to reach is replacement in a full table under a specific recency order, combined with faults, bypassed accesses and rejected permission checks. None of these three may disturb the ranking, so the evicted slot depends on the whole history since reset. The stimulus draws pages from a pool of twelve, so the eight slots fill quickly and old pages keep returning. A bench model of true LRU then predicts which page must now miss. Directed sequences add a deliberate touch order before a ninth install, a reinstall of a resident page, and a fault that collides with a page/perm write.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int OFF_W     = 12;
  localparam int FRAME_W   = 26;
  localparam int REG_W     = 32;
  localparam int PAGE_W    = VA_W - OFF_W;
  localparam int PA_W      = FRAME_W + OFF_W;
  localparam int FRAME_LSB = REG_W - FRAME_W;
  localparam int CODE_W    = 5;
  localparam int PERM_W    = 4;

  localparam int PB_V = 3;
  localparam int PB_R = 2;
  localparam int PB_W = 1;
  localparam int PB_X = 0;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_READ2 = 2'b11
  } access_kind_e;

  localparam logic [CODE_W-1:0] CODE_MISS  = 5'b01000;
  localparam logic [CODE_W-1:0] CODE_READ  = 5'b00100;
  localparam logic [CODE_W-1:0] CODE_WRITE = 5'b00010;
  localparam logic [CODE_W-1:0] CODE_FETCH = 5'b00001;

  typedef struct packed {
    logic                install;
    logic [PAGE_W-1:0]   page;
    logic [PERM_W-1:0]   perm;
    logic [FRAME_W-1:0]  frame;
  } install_strobe_t;
endpackage

// File: rtl/tlb_dpath.sv
`timescale 1ns/1ps
module tlb_dpath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [VA_W-1:0]        reqAddr,
  input  logic [1:0]             reqKind,
  input  install_strobe_t        inst,
  input  logic [IDX_W-1:0]       instSlot,
  output logic                   hit,
  output logic                   fault,
  output logic [PA_W-1:0]        physAddr,
  output logic [CODE_W-1:0]      faultCode,
  output logic [IDX_W-1:0]       hitSlot,
  output logic                   instFound,
  output logic [IDX_W-1:0]       instFoundSlot,
  output logic [ENTRIES-1:0]     occVec
);
  logic [ENTRIES-1:0] occQ;
  logic [PAGE_W-1:0]  pageQ  [ENTRIES];
  logic [PERM_W-1:0]  permQ  [ENTRIES];
  logic [FRAME_W-1:0] frameQ [ENTRIES];

  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] inMatch;
  logic [PAGE_W-1:0]  reqPage;
  logic [IDX_W-1:0]   lkIdx;
  logic [IDX_W-1:0]   inIdx;
  logic [PERM_W-1:0]  selPerm;
  logic               found;
  logic               allowed;
  logic               translate;
  logic               needBit;
  logic [CODE_W-1:0]  kindCode;

  assign reqPage = reqAddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lkMatch[g] = occQ[g] && (pageQ[g] == reqPage);
    assign inMatch[g] = occQ[g] && (pageQ[g] == inst.page);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pageQ[i]  <= '0;
        permQ[i]  <= '0;
        frameQ[i] <= '0;
      end
    end else if (inst.install) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (instSlot == IDX_W'(i)) begin
          occQ[i]   <= 1'b1;
          pageQ[i]  <= inst.page;
          permQ[i]  <= inst.perm;
          frameQ[i] <= inst.frame;
        end
      end
    end
  end

  always_comb begin
    lkIdx = '0;
    inIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatch[i]) lkIdx = IDX_W'(i);
      if (inMatch[i]) inIdx = IDX_W'(i);
    end
  end

  always_comb begin
    selPerm = permQ[lkIdx];
    unique case (access_kind_e'(reqKind))
      KIND_WRITE: begin needBit = selPerm[PB_W]; kindCode = CODE_WRITE; end
      KIND_FETCH: begin needBit = selPerm[PB_X]; kindCode = CODE_FETCH; end
      default:    begin needBit = selPerm[PB_R]; kindCode = CODE_READ;  end
    endcase
  end

  assign found     = |lkMatch;
  assign translate = reqValid && reqAddr[VA_W-1];
  assign allowed   = found && selPerm[PB_V] && needBit;
  assign hit       = translate && allowed;
  assign fault     = translate && !allowed;
  assign faultCode = (!found || !selPerm[PB_V]) ? CODE_MISS : kindCode;
  assign physAddr  = reqAddr[VA_W-1] ? {frameQ[lkIdx], reqAddr[OFF_W-1:0]}
                                     : PA_W'(reqAddr);
  assign hitSlot       = lkIdx;
  assign instFound     = |inMatch;
  assign instFoundSlot = inIdx;
  assign occVec        = occQ;

  // R2/R3: a lookup never both succeeds and fails
  a_r2_hit_fault_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && fault));

  // R1: untranslated accesses are silent
  a_r1_bypass_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqAddr[VA_W-1]) |-> (!hit && !fault));

  // R8: a page is never resident in two slots
  a_r8_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch));

  // R7: an installed slot is occupied and holds the page afterwards
  a_r7_install_lands: assert property (@(posedge clk) disable iff (!rstN)
    inst.install |=> (occQ[$past(instSlot)] && pageQ[$past(instSlot)] == $past(inst.page)));
endmodule

// File: rtl/tlb_ctrl.sv
`timescale 1ns/1ps
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regWrSel,
  input  logic [REG_W-1:0]       regWrData,
  input  logic                   regRdSel,
  output logic [REG_W-1:0]       regRdData,
  input  logic [VA_W-1:0]        reqAddr,
  input  logic                   hit,
  input  logic                   fault,
  input  logic [CODE_W-1:0]      faultCode,
  input  logic [IDX_W-1:0]       hitSlot,
  input  logic                   instFound,
  input  logic [IDX_W-1:0]       instFoundSlot,
  input  logic [ENTRIES-1:0]     occVec,
  output install_strobe_t        inst,
  output logic [IDX_W-1:0]       instSlot
);
  localparam int PAD_W = OFF_W - CODE_W;

  logic [REG_W-1:0]  prQ;
  logic [REG_W-1:0]  frQ;
  logic [IDX_W-1:0]  ageQ [ENTRIES];
  logic              wrPr;
  logic              wrFr;
  logic              anyFree;
  logic [IDX_W-1:0]  firstFree;
  logic [IDX_W-1:0]  lruSlot;
  logic [ENTRIES-1:0] oldestVec;
  logic              touchEn;
  logic [IDX_W-1:0]  touchSlot;
  logic [IDX_W-1:0]  touchAge;

  assign wrPr = regWrEn && !regWrSel;
  assign wrFr = regWrEn &&  regWrSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prQ <= '0;
      frQ <= '0;
    end else begin
      if (fault)
        prQ <= {reqAddr[VA_W-1:OFF_W], {PAD_W{1'b0}}, faultCode};
      else if (wrPr)
        prQ <= regWrData;
      if (wrFr)
        frQ <= regWrData;
    end
  end

  assign regRdData = regRdSel ? frQ : prQ;

  assign inst.install = wrFr;
  assign inst.page    = prQ[REG_W-1:OFF_W];
  assign inst.perm    = prQ[PERM_W-1:0];
  assign inst.frame   = regWrData[REG_W-1:FRAME_LSB];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldestVec[g] = (ageQ[g] == IDX_W'(ENTRIES-1));
  end

  always_comb begin
    anyFree   = 1'b0;
    firstFree = '0;
    lruSlot   = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (!occVec[i]) begin
        anyFree   = 1'b1;
        firstFree = IDX_W'(i);
      end
      if (oldestVec[i]) lruSlot = IDX_W'(i);
    end
  end

  assign instSlot  = instFound ? instFoundSlot : (anyFree ? firstFree : lruSlot);
  assign touchEn   = wrFr || hit;
  assign touchSlot = wrFr ? instSlot : hitSlot;
  assign touchAge  = ageQ[touchSlot];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ageQ[i] <= IDX_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (touchSlot == IDX_W'(i))
          ageQ[i] <= '0;
        else if (ageQ[i] < touchAge)
          ageQ[i] <= ageQ[i] + 1'b1;
      end
    end
  end

  // R4: the fault record carries the faulting page
  a_r4_fault_page: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> (prQ[REG_W-1:OFF_W] == $past(reqAddr[VA_W-1:OFF_W])));

  // R4: exactly one code bit names the failure
  a_r4_code_onehot: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> $onehot(prQ[CODE_W-1:0]));

  // R9: the recency ranking always has a single oldest slot
  a_r9_single_oldest: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(oldestVec));

  // R9: a touched slot becomes most recent
  a_r9_touch_newest: assert property (@(posedge clk) disable iff (!rstN)
    touchEn |=> (ageQ[$past(touchSlot)] == '0));

  // R6: a frame write is held as written
  a_r6_frame_held: assert property (@(posedge clk) disable iff (!rstN)
    wrFr |=> (frQ == $past(regWrData)));
endmodule

// File: rtl/soft_tlb.sv
`timescale 1ns/1ps
module soft_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic [1:0]        reqKind,
  output logic              hit,
  output logic              fault,
  output logic [37:0]       physAddr,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic [31:0]       regWrData,
  input  logic              regRdSel,
  output logic [31:0]       regRdData
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  install_strobe_t    inst;
  logic [IDX_W-1:0]   instSlot;
  logic [CODE_W-1:0]  faultCode;
  logic [IDX_W-1:0]   hitSlot;
  logic               instFound;
  logic [IDX_W-1:0]   instFoundSlot;
  logic [ENTRIES-1:0] occVec;

  tlb_dpath #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqAddr       (reqAddr),
    .reqKind       (reqKind),
    .inst          (inst),
    .instSlot      (instSlot),
    .hit           (hit),
    .fault         (fault),
    .physAddr      (physAddr),
    .faultCode     (faultCode),
    .hitSlot       (hitSlot),
    .instFound     (instFound),
    .instFoundSlot (instFoundSlot),
    .occVec        (occVec)
  );

  tlb_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .regWrEn       (regWrEn),
    .regWrSel      (regWrSel),
    .regWrData     (regWrData),
    .regRdSel      (regRdSel),
    .regRdData     (regRdData),
    .reqAddr       (reqAddr),
    .hit           (hit),
    .fault         (fault),
    .faultCode     (faultCode),
    .hitSlot       (hitSlot),
    .instFound     (instFound),
    .instFoundSlot (instFoundSlot),
    .occVec        (occVec),
    .inst          (inst),
    .instSlot      (instSlot)
  );
endmodule

// File: tb/test_soft_tlb.sv
`timescale 1ns/1ps
module test_soft_tlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        hit, fault;
  logic [37:0] physAddr;
  logic        regWrEn = 1'b0;
  logic        regWrSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdSel = 1'b0;
  logic [31:0] regRdData;

  soft_tlb i_soft_tlb (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .hit(hit), .fault(fault), .physAddr(physAddr),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .regRdSel(regRdSel), .regRdData(regRdData)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  bit          mOcc  [8];
  logic [19:0] mPage [8];
  logic [3:0]  mPerm [8];
  logic [25:0] mFrm  [8];
  int          mAge  [8];
  logic [31:0] mPr = '0;
  logic [31:0] mFr = '0;

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic touch(input int s);
    int a = mAge[s];
    for (int i = 0; i < 8; i++) begin
      if (i == s) mAge[i] = 0;
      else if (mAge[i] < a) mAge[i]++;
    end
  endtask

  task automatic step(input string tag, input bit v, input logic [31:0] a,
                      input logic [1:0] k, input bit we, input bit ws,
                      input logic [31:0] wd, input bit rs);
    bit found = 0;
    int idx = 0;
    bit need, allowed, eHit, eFault;
    logic [4:0]  code;
    logic [37:0] ePa;
    logic [31:0] oldPr;
    int slot;
    reqValid = v; reqAddr = a; reqKind = k;
    regWrEn = we; regWrSel = ws; regWrData = wd; regRdSel = rs;
    #4;
    for (int i = 0; i < 8; i++)
      if (mOcc[i] && mPage[i] == a[31:12]) begin found = 1; idx = i; end
    need = (k == 2'b01) ? mPerm[idx][1] : (k == 2'b10) ? mPerm[idx][0] : mPerm[idx][2];
    allowed = found && mPerm[idx][3] && need;
    eHit   = v && a[31] && allowed;
    eFault = v && a[31] && !allowed;
    ePa = a[31] ? {mFrm[idx], a[11:0]} : {6'b0, a};
    code = (!found || !mPerm[idx][3]) ? 5'b01000 :
           (k == 2'b01) ? 5'b00010 : (k == 2'b10) ? 5'b00001 : 5'b00100;
    check(tag, "hit", 64'(hit), 64'(eHit));
    check(tag, "fault", 64'(fault), 64'(eFault));
    if (eHit || (v && !a[31])) check(tag, "physAddr", 64'(physAddr), 64'(ePa));
    check(tag, "regRdData", 64'(regRdData), 64'(rs ? mFr : mPr));
    oldPr = mPr;
    if (eFault) mPr = {a[31:12], 7'b0, code};
    else if (we && !ws) mPr = wd;
    if (we && ws) begin
      slot = -1;
      for (int i = 0; i < 8; i++)
        if (mOcc[i] && mPage[i] == oldPr[31:12]) slot = i;
      if (slot < 0)
        for (int i = 7; i >= 0; i--) if (!mOcc[i]) slot = i;
      if (slot < 0)
        for (int i = 0; i < 8; i++) if (mAge[i] == 7) slot = i;
      mFr = wd;
      mOcc[slot] = 1; mPage[slot] = oldPr[31:12];
      mPerm[slot] = oldPr[3:0]; mFrm[slot] = wd[31:6];
      touch(slot);
    end else if (eHit) begin
      touch(idx);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic [1:0] k, input bit rs);
    step(tag, 1'b1, a, k, 1'b0, 1'b0, 32'h0, rs);
  endtask

  task automatic install(input string tag, input logic [19:0] pg, input logic [4:0] perm,
                         input logic [25:0] frm);
    step(tag, 1'b0, 32'h0, 2'b00, 1'b1, 1'b0, {pg, 7'h15, perm}, 1'b0);
    step(tag, 1'b0, 32'h0, 2'b00, 1'b1, 1'b1, {frm, 6'h2A}, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mOcc[i] = 0; mPage[i] = '0; mPerm[i] = '0; mFrm[i] = '0; mAge[i] = i;
    end
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: empty after reset, registers zero
    look("R10", 32'h8000_5123, 2'b00, 1'b1);
    // R4: miss recorded with v code
    look("R4", 32'h0000_0000, 2'b00, 1'b0);

    // R7/R6: fill eight slots (one with m set); R9 lowest free first
    for (int i = 0; i < 8; i++)
      install("R7", 20'h80010 + 20'(i), (i == 3) ? 5'h1F : 5'h0F, 26'h100_0000 + 26'(i * 7));
    for (int i = 0; i < 8; i++)
      look("R2", {20'h80010 + 20'(i), 12'h3A5}, 2'(i % 3), 1'b0);

    // R9: touch all except page +2, then a ninth install evicts it
    for (int i = 0; i < 8; i++)
      if (i != 2) look("R9", {20'h80010 + 20'(i), 12'h000}, 2'b00, 1'b0);
    install("R9", 20'h80020, 5'h0F, 26'h2AA_AAAA);
    look("R9", 32'h8001_2000, 2'b00, 1'b0);
    look("R9", 32'h8002_0FFF, 2'b10, 1'b0);

    // R8: reinstall resident page with new frame
    install("R8", 20'h80015, 5'h0F, 26'h155_5555);
    look("R8", 32'h8001_5ABC, 2'b01, 1'b0);
    look("R8", 32'h8001_6ABC, 2'b01, 1'b0);

    // R3: permission variants
    install("R3", 20'h80015, 5'h0C, 26'h0AB_CDEF);
    look("R3", 32'h8001_5004, 2'b00, 1'b0);
    look("R3", 32'h8001_5004, 2'b01, 1'b0);
    look("R3", 32'h8001_5004, 2'b10, 1'b0);
    look("R3", 32'h8001_5004, 2'b11, 1'b0);
    install("R3", 20'h80016, 5'h07, 26'h011_1111);
    look("R3", 32'h8001_6008, 2'b00, 1'b0);
    install("R3", 20'h80017, 5'h18, 26'h022_2222);
    look("R3", 32'h8001_700C, 2'b00, 1'b0);

    // R1: bypass passes through and leaves register alone
    look("R1", 32'h0000_1000, 2'b01, 1'b0);
    look("R1", 32'h7FFF_FFFF, 2'b10, 1'b0);

    // R5: fault beats same-cycle page/perm write
    step("R5", 1'b1, 32'h8009_9000, 2'b00, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0);
    look("R5", 32'h0000_0000, 2'b00, 1'b0);
    // R6: page/perm write lands when no fault
    step("R6", 1'b0, 32'h0, 2'b00, 1'b1, 1'b0, 32'h1234_5678, 1'b0);
    look("R6", 32'h0000_0000, 2'b00, 1'b0);

    // random mix, page pool of twelve
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a;
      logic [31:0] r = $urandom;
      a = {1'b1, 15'h0, 4'($urandom_range(0, 11)), 12'($urandom)};
      if (r[3:0] == 0) a[31] = 1'b0;
      case (r[6:4])
        3'd0: step("R7", r[7], a, 2'($urandom), 1'b1, 1'b1, $urandom, r[8]);
        3'd1: step("R6", r[7], a, 2'($urandom), 1'b1, 1'b0,
                   {1'b1, 15'h0, 4'($urandom_range(0, 11)), 7'h0, 5'($urandom)}, r[8]);
        default: step("R2", 1'b1, a, 2'($urandom), 1'b0, 1'b0, 32'h0, r[8]);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule